// File: doc/BRIEF.md
# Three-Way Split Significand Multiplier

This block multiplies two 53-bit unsigned significands, hidden bit included, and returns the full 106-bit product. Each operand is cut into a low 18-bit segment, a middle 18-bit segment and a top 17-bit segment. Three diagonal products are formed, one for each pair of same-position segments. Each of the three cross terms is then formed as one product of two segment sums, less the two matching diagonal products. The whole product therefore needs six multiplications where a plain split would need nine.

The work runs through a four-stage pipeline. Stage 1 registers the segments and their pairwise sums. Stage 2 registers the six sub-products. Stage 3 subtracts to get the cross terms. Stage 4 adds every term in at its weight, using powers of 2^18.

Operands enter on a valid/ready stream and the product leaves on a valid/ready stream. Back-pressure stalls the whole pipeline together, in one step. While the output holds a product that has not been taken, no stage advances and `in_ready` is low. In every other cycle `in_ready` is high and one pair can be accepted in each cycle.

Top module: `karat3_mul`

## Requirements
- R1: For every accepted pair (a, b), the product delivered is exactly a*b as a 106-bit unsigned value. This includes zero and operands whose top bit is clear.
- R2: If out_ready stays high, a pair accepted in clock cycle n appears with out_valid high in cycle n+4.
- R3: in_ready is high in any cycle where out_ready is high or out_valid is low. It is low when out_valid is high and out_ready is low.
- R4: While out_valid is high and out_ready is low, out_valid stays high in the next cycle and out_product keeps the same value.
- R5: The reset is synchronous and active low. After a clock edge with rst_n low, out_valid is low and every pair still in flight is dropped.
- R6: Each cross term, a sum product less its two diagonal products, is never negative and fits in 38 bits. This holds even when every segment is all ones.
- R7: Products leave in the order their pairs were accepted. No pair is lost or repeated across gaps in in_valid or stalls from out_ready.
- R8: The corner operands give exact results:
  - all ones (2^53-1) squared gives 2^106-2^54+1;
  - 2^52 squared gives 2^104;
  - alternating patterns whose bit 52 is 1 or 0 give their exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | 53 | First significand |
| in_b | input | 53 | Second significand |
| out_valid | output | 1 | Product is present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_product | output | 106 | 106-bit unsigned product |

## Verification
The bench drives operands that stress the Karatsuba identity: all-ones segments, which give the largest segment sums and cross terms, along with the minimum normal significand, alternating patterns and zero. A bad segment boundary, a segment sum one bit too narrow, or a wrong shift weight on any term would corrupt the high or middle product bits of these cases. Random traffic with gaps and random back-pressure catches a pipeline that does not stall every stage together; such a design would drop, repeat or reorder products, or change a product while it is being held. A reset in the middle of a stall checks that pairs still in flight never reach the output.

// File: rtl/karat3_pkg.sv
package karat3_pkg;

  // Number of segments each operand is cut into.
  localparam int NSEG = 3;

  // Cross term k pairs segment hi(k) with segment lo(k):
  // k=2 -> (2,1), k=1 -> (2,0), k=0 -> (1,0)
  function automatic int pair_hi(input int k);
    return (k == 0) ? 1 : 2;
  endfunction

  function automatic int pair_lo(input int k);
    return (k == 2) ? 1 : 0;
  endfunction

endpackage

// File: rtl/karat3_split.sv
// Stage 1: cut operands into segments and form pairwise segment sums.
module karat3_split #(
  parameter int W   = 53,
  parameter int SEG = 18,
  localparam int SUMW = SEG + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic                  in_vld,
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  output logic                  out_vld,
  output logic [2:0][SEG-1:0]   seg_a,
  output logic [2:0][SEG-1:0]   seg_b,
  output logic [2:0][SUMW-1:0]  sum_a,
  output logic [2:0][SUMW-1:0]  sum_b
);
  import karat3_pkg::*;

  logic [2:0][SEG-1:0]  cut_a, cut_b;
  logic [2:0][SUMW-1:0] add_a, add_b;

  always_comb begin
    cut_a[0] = a[SEG-1:0];
    cut_a[1] = a[2*SEG-1:SEG];
    cut_a[2] = SEG'(a[W-1:2*SEG]);
    cut_b[0] = b[SEG-1:0];
    cut_b[1] = b[2*SEG-1:SEG];
    cut_b[2] = SEG'(b[W-1:2*SEG]);
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_sum
    localparam int HI = pair_hi(k);
    localparam int LO = pair_lo(k);
    assign add_a[k] = {1'b0, cut_a[HI]} + {1'b0, cut_a[LO]};
    assign add_b[k] = {1'b0, cut_b[HI]} + {1'b0, cut_b[LO]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else if (adv) begin
      out_vld <= in_vld;
      seg_a   <= cut_a;
      seg_b   <= cut_b;
      sum_a   <= add_a;
      sum_b   <= add_b;
    end
  end

endmodule

// File: rtl/karat3_prods.sv
// Stage 2: three diagonal products and three segment-sum products.
module karat3_prods #(
  parameter int SEG = 18,
  localparam int SUMW = SEG + 1,
  localparam int DW   = 2 * SEG,
  localparam int PW   = 2 * SUMW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 in_vld,
  input  logic [2:0][SEG-1:0]  seg_a,
  input  logic [2:0][SEG-1:0]  seg_b,
  input  logic [2:0][SUMW-1:0] sum_a,
  input  logic [2:0][SUMW-1:0] sum_b,
  output logic                 out_vld,
  output logic [2:0][DW-1:0]   diag,
  output logic [2:0][PW-1:0]   sprod
);
  import karat3_pkg::*;

  logic [2:0][DW-1:0] diag_c;
  logic [2:0][PW-1:0] sprod_c;

  for (genvar k = 0; k < NSEG; k++) begin : g_mul
    assign diag_c[k]  = DW'(seg_a[k]) * DW'(seg_b[k]);
    assign sprod_c[k] = PW'(sum_a[k]) * PW'(sum_b[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else if (adv) begin
      out_vld <= in_vld;
      diag    <= diag_c;
      sprod   <= sprod_c;
    end
  end

endmodule

// File: rtl/karat3_cross.sv
// Stage 3: cross term = sum product - two diagonal products.
module karat3_cross #(
  parameter int SEG = 18,
  localparam int SUMW = SEG + 1,
  localparam int DW   = 2 * SEG,
  localparam int PW   = 2 * SUMW,
  localparam int PW1  = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 in_vld,
  input  logic [2:0][DW-1:0]   diag_in,
  input  logic [2:0][PW-1:0]   sprod,
  output logic                 out_vld,
  output logic [2:0][DW-1:0]   diag,
  output logic [2:0][PW-1:0]   beta
);
  import karat3_pkg::*;

  logic [2:0][PW-1:0] beta_c;

  for (genvar k = 0; k < NSEG; k++) begin : g_cross
    localparam int HI = pair_hi(k);
    localparam int LO = pair_lo(k);
    assign beta_c[k] = sprod[k] - PW'(diag_in[HI]) - PW'(diag_in[LO]);

    // R6: the subtraction never borrows, so the unsigned cross term is exact
    p_beta_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> (PW1'(sprod[k]) >= (PW1'(diag_in[HI]) + PW1'(diag_in[LO]))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else if (adv) begin
      out_vld <= in_vld;
      diag    <= diag_in;
      beta    <= beta_c;
    end
  end

endmodule

// File: rtl/karat3_accum.sv
// Stage 4: weighted accumulation in powers of 2^SEG.
module karat3_accum #(
  parameter int W   = 53,
  parameter int SEG = 18,
  localparam int SUMW = SEG + 1,
  localparam int DW   = 2 * SEG,
  localparam int PW   = 2 * SUMW,
  localparam int OW   = 2 * W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                in_vld,
  input  logic [2:0][DW-1:0]  diag,
  input  logic [2:0][PW-1:0]  beta,
  output logic                out_vld,
  output logic [OW-1:0]       prod
);

  logic [OW-1:0] total;

  always_comb begin
    total = (OW'(diag[2]) << (4*SEG))
          + (OW'(beta[2]) << (3*SEG))
          + ((OW'(diag[1]) + OW'(beta[1])) << (2*SEG))
          + (OW'(beta[0]) << SEG)
          + OW'(diag[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else if (adv) begin
      out_vld <= in_vld;
      prod    <= total;
    end
  end

endmodule

// File: rtl/karat3_mul.sv
module karat3_mul #(
  parameter int W   = 53,
  parameter int SEG = 18,
  localparam int SUMW = SEG + 1,
  localparam int DW   = 2 * SEG,
  localparam int PW   = 2 * SUMW,
  localparam int OW   = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_product
);

  logic                 adv;
  logic                 v1, v2, v3;
  logic [2:0][SEG-1:0]  seg_a, seg_b;
  logic [2:0][SUMW-1:0] sum_a, sum_b;
  logic [2:0][DW-1:0]   diag2, diag3;
  logic [2:0][PW-1:0]   sprod, beta;

  // Whole pipeline moves together unless a finished product is stuck.
  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  karat3_split #(.W(W), .SEG(SEG)) u_split (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_vld(in_valid),
    .a(in_a), .b(in_b), .out_vld(v1),
    .seg_a(seg_a), .seg_b(seg_b), .sum_a(sum_a), .sum_b(sum_b)
  );

  karat3_prods #(.SEG(SEG)) u_prods (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_vld(v1),
    .seg_a(seg_a), .seg_b(seg_b), .sum_a(sum_a), .sum_b(sum_b),
    .out_vld(v2), .diag(diag2), .sprod(sprod)
  );

  karat3_cross #(.SEG(SEG)) u_cross (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_vld(v2),
    .diag_in(diag2), .sprod(sprod),
    .out_vld(v3), .diag(diag3), .beta(beta)
  );

  karat3_accum #(.W(W), .SEG(SEG)) u_accum (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_vld(v3),
    .diag(diag3), .beta(beta),
    .out_vld(out_valid), .prod(out_product)
  );

  // R3: a waiting consumer never blocks new operands
  p_ready_when_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  // R3: a stalled output blocks the input
  p_block_on_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4: a held product stays put
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

  // R2: fixed latency of four cycles with no back-pressure
  p_latency_four_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 4) && $past(rst_n, 4) && $past(rst_n, 3) &&
     $past(rst_n, 2) && $past(rst_n, 1) && $past(out_ready, 1) &&
     $past(out_ready, 2) && $past(out_ready, 3)) |-> out_valid);

  // R5: synchronous reset empties the output
  p_reset_idle_r5: assert property (@(posedge clk) !rst_n |=> !out_valid);

endmodule

// File: tb/karat3_mul_bench.sv
`timescale 1ns/1ps
module karat3_mul_bench;

  localparam int W  = 53;
  localparam int OW = 2 * W;
  localparam int NV = 10;

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALT1 = {1'b1, {26{2'b01}}};
  localparam logic [W-1:0] ALT0 = {1'b0, {26{2'b10}}};
  localparam logic [W-1:0] LOW2 = {1'b1, 16'h0000, {36{1'b1}}};

  // stimulus table: operand a, operand b, requirement tag (expected = a*b)
  localparam logic [W-1:0] TAB_A [0:NV-1] = '{ONES, MINN, ALT1, ALT1, ONES,
    LOW2, {W{1'b0}}, 53'd1, MINN | 53'd1, 53'h0123456789ABC};
  localparam logic [W-1:0] TAB_B [0:NV-1] = '{ONES, MINN, ALT1, ALT0, MINN,
    ONES, ONES, 53'd1, ONES, ALT1};
  localparam int TAB_T [0:NV-1] = '{8, 8, 8, 8, 8, 6, 1, 1, 1, 1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OW-1:0] out_product;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit check_lat = 1'b0;
  bit prev_stall = 1'b0;
  bit finished = 1'b0;
  logic [OW-1:0] prev_prod;
  logic [OW-1:0] q_exp [$];
  int            q_cyc [$];
  int            q_tag [$];

  always #2 clk = ~clk;

  karat3_mul u_karat3_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_product(out_product)
  );

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act,
                     input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic observe;
    logic [OW-1:0] e;
    int ac, tg;
    // R3: back-pressure rule
    if (out_ready) chk(in_ready, "R3", OW'(in_ready), OW'(1));
    if (out_valid && !out_ready) chk(!in_ready, "R3", OW'(in_ready), OW'(0));
    // R4: product held during stall
    if (prev_stall) begin
      chk(out_valid, "R4", OW'(out_valid), OW'(1));
      chk(out_product == prev_prod, "R4", out_product, prev_prod);
    end
    if (out_valid && out_ready) begin
      if (q_exp.size() == 0) begin
        chk(1'b0, "R7", out_product, '0);
      end else begin
        e = q_exp.pop_front(); ac = q_cyc.pop_front(); tg = q_tag.pop_front();
        if (tg == 8)      chk(out_product == e, "R8", out_product, e);
        else if (tg == 6) chk(out_product == e, "R6", out_product, e);
        else              chk(out_product == e, "R1/R7", out_product, e);
        if (check_lat) chk(cyc - ac == 4, "R2", OW'(cyc - ac), OW'(4));
      end
    end
    if (in_valid && in_ready) begin
      q_exp.push_back({{W{1'b0}}, in_a} * {{W{1'b0}}, in_b});
      q_cyc.push_back(cyc);
      q_tag.push_back(0);
    end
    prev_stall = out_valid && !out_ready;
    prev_prod  = out_product;
  endtask

  task automatic cycle(input bit iv, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit ordy, input int tag);
    @(negedge clk);
    in_valid = iv; in_a = a; in_b = b; out_ready = ordy;
    #1;
    observe();
    if (iv && in_ready && tag != 0) q_tag[q_tag.size()-1] = tag;
    cyc++;
  endtask

  task automatic drain;
    for (int i = 0; i < 40 && q_exp.size() != 0; i++) cycle(1'b0, '0, '0, 1'b1, 0);
    chk(q_exp.size() == 0, "R7", OW'(q_exp.size()), OW'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R5", OW'(out_valid), OW'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // table walk, back-to-back, no back-pressure: R1, R2, R6, R8
    check_lat = 1'b1;
    for (int i = 0; i < NV; i++) cycle(1'b1, TAB_A[i], TAB_B[i], 1'b1, TAB_T[i]);
    drain();
    check_lat = 1'b0;

    // random traffic with gaps and back-pressure: R1, R3, R4, R7
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'({$urandom(), $urandom()});
      rb = W'({$urandom(), $urandom()});
      if (i % 3 == 0) begin ra[W-1] = 1'b1; rb[W-1] = 1'b1; end
      cycle(($urandom() % 4) != 0, ra, rb, ($urandom() % 3) != 0, 0);
    end
    drain();

    // corner operands again, this time under a stall (R8, R4)
    for (int i = 0; i < 5; i++) cycle(1'b1, TAB_A[i], TAB_B[i], 1'b0, TAB_T[i]);
    for (int i = 0; i < 6; i++) cycle(1'b0, '0, '0, 1'b0, 0);
    drain();

    // reset while products are in flight: R5
    for (int i = 0; i < 3; i++) cycle(1'b1, ONES, ALT1, 1'b0, 0);
    for (int i = 0; i < 3; i++) cycle(1'b0, '0, '0, 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid, "R5", OW'(out_valid), OW'(0));
    rst_n = 1'b1;
    q_exp.delete(); q_cyc.delete(); q_tag.delete();
    prev_stall = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1;
      chk(!out_valid, "R5", OW'(out_valid), OW'(0));
    end

    // pipeline works again after reset
    check_lat = 1'b1;
    cycle(1'b1, MINN, MINN, 1'b1, 8);
    drain();

    finished = 1'b1;
    report();
    $finish;
  end

endmodule